// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Controller

This block supervises the clock and data lines of a two-wire bus on the downstream side of a channel multiplexer. It watches for a bus that never reaches the state where both lines are high together. If that state does not occur for a programmable number of system-clock cycles while at least one downstream channel is switched on, the block declares the bus stuck and raises a sticky fault flag.

A static strap input selects what happens next. With the strap low, the block only reports the fault. With the strap high, it also asks the surrounding logic to isolate the upstream side and then runs a recovery sequence of its own: a settling wait, a burst of slow clock pulses on SCL, and a STOP condition. The burst ends early as soon as the bus is seen free during a released phase. All bus outputs are open-drain pull-down requests, so a 1 means "pull the line low" and a 0 means "release".

The line inputs pass through a synchronizer of `SYNC_STAGES` flops before any decision is made. All lengths are parameters given in system-clock cycles, so a testbench can shrink them.

Top module: `bus_unstick_ctrl`

## Requirements
- R1: While monitoring is active, `fault` rises after `TIMEOUT_CYC` consecutive synchronized cycles in which SCL and SDA are not both high (`SYNC_STAGES` extra cycles of latency from the pins); any single cycle with both lines high restarts the count.
- R2: While every bit of `chan_en` is 0, no fault is detected however long the bus stays low.
- R3: `fault` rises on detection whatever the value of `disc_strap`; `disconnect` rises in the same cycle only when `disc_strap` is 1.
- R4: With `disc_strap` at 1, `scl_drive_low` first goes to 1 exactly `WAIT_CYC` cycles after `fault` rises.
- R5: Each recovery clock pulse holds `scl_drive_low` at 1 for `HALF_CYC` cycles and releases it for `HALF_CYC` cycles, `sda_drive_low` stays 0 throughout the burst, and no more than `MAX_PULSES` pulses are produced.
- R6: The burst is followed by exactly one STOP: `sda_drive_low` and `scl_drive_low` go to 1 together, SCL is then released while SDA is still held, and SDA is released last while SCL is released.
- R7: If both lines are seen high during the wait or during a released SCL phase, no further pulse is produced and the STOP is generated at once.
- R8: With `disc_strap` at 0, a fault never causes `disconnect`, `scl_drive_low` or `sda_drive_low` to become 1.
- R9: `fault` and `disconnect` stay set until `clr_req` is 1 in a cycle where the synchronized bus is idle-high and no recovery sequence is running; they then both clear on the next clock edge, and a clear request at any other time has no effect.
- R10: During and right after reset, `fault`, `disconnect`, `scl_drive_low` and `sda_drive_low` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sampled level of the shared downstream SCL node |
| sda_i | input | 1 | Sampled level of the shared downstream SDA node |
| chan_en | input | N_CHAN | Downstream channel enables; monitoring needs at least one set |
| disc_strap | input | 1 | Static strap: 1 selects isolate-and-recover, 0 selects flag only |
| clr_req | input | 1 | Request to clear the fault flag |
| scl_drive_low | output | 1 | Open-drain request to pull SCL low |
| sda_drive_low | output | 1 | Open-drain request to pull SDA low |
| disconnect | output | 1 | Request to isolate upstream from downstream |
| fault | output | 1 | Sticky stuck-bus flag |

## Verification
Two functions meet in one cycle when the bus frees itself during the final released phase of the burst: the early-exit path and the pulse-limit path both want to move to the STOP. The bench provokes this by releasing SDA exactly when the last pulse starts, and judges it by counting that the burst still has the full number of pulses and that exactly one STOP follows. A second meeting point is a clear request held high while the sequence sees the bus free and leaves for the STOP; the bench holds `clr_req` across that moment and checks that the flag never drops while SDA is still being driven.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;

  // Recovery sequencer phases
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_WAIT   = 3'd1,
    SQ_LOW    = 3'd2,
    SQ_HIGH   = 3'd3,
    SQ_STOP_A = 3'd4,
    SQ_STOP_B = 3'd5
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;

  // Flops reset to the released (high) level so that reset looks idle
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic scl_in;
    logic sda_in;
    if (g == 0) begin : g_first
      assign scl_in = scl_raw;
      assign sda_in = sda_raw;
    end else begin : g_next
      assign scl_in = scl_q[g-1];
      assign sda_in = sda_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_q[g] <= 1'b1;
        sda_q[g] <= 1'b1;
      end else begin
        scl_q[g] <= scl_in;
        sda_q[g] <= sda_in;
      end
    end
  end

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

endmodule

// File: rtl/stuck_window_timer.sv
module stuck_window_timer #(
  parameter int TIMEOUT_CYC = 2_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic bus_idle,
  input  logic hold,
  output logic timeout_hit
);

  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          counting;
  logic          cnt_en;

  assign counting    = mon_en && !bus_idle && !hold;
  assign timeout_hit = counting && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!counting) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != LAST) begin
      cnt_d  = cnt_q + CW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/recovery_sequencer.sv
module recovery_sequencer
  import bus_unstick_pkg::*;
#(
  parameter int WAIT_CYC   = 2000,
  parameter int HALF_CYC   = 4545,
  parameter int MAX_PULSES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bus_idle,
  output logic scl_low,
  output logic sda_low,
  output logic busy
);

  localparam int LONGEST = max2(WAIT_CYC, HALF_CYC);
  localparam int TW      = $clog2(LONGEST + 1);
  localparam int PW      = $clog2(MAX_PULSES + 1);
  localparam logic [TW-1:0] WAIT_LAST = TW'(WAIT_CYC - 1);
  localparam logic [TW-1:0] HALF_LAST = TW'(HALF_CYC - 1);
  localparam logic [PW-1:0] PULSE_MAX = PW'(MAX_PULSES);

  seq_state_t    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [PW-1:0] pc_q, pc_d;
  logic [PW-1:0] pc_inc;
  logic          tmr_step;

  assign pc_inc   = pc_q + PW'(1);
  assign tmr_step = 1'b1;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    pc_d  = pc_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d  = SQ_WAIT;
          tmr_d = '0;
          pc_d  = '0;
        end
      end
      SQ_WAIT: begin
        if (bus_idle) begin
          st_d  = SQ_STOP_A;
          tmr_d = '0;
        end else if (tmr_q == WAIT_LAST) begin
          st_d  = SQ_LOW;
          tmr_d = '0;
        end else if (tmr_step) begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      SQ_LOW: begin
        if (tmr_q == HALF_LAST) begin
          st_d  = SQ_HIGH;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      SQ_HIGH: begin
        if (bus_idle) begin
          st_d  = SQ_STOP_A;
          tmr_d = '0;
        end else if (tmr_q == HALF_LAST) begin
          pc_d  = pc_inc;
          tmr_d = '0;
          st_d  = (pc_inc == PULSE_MAX) ? SQ_STOP_A : SQ_LOW;
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      SQ_STOP_A: begin
        if (tmr_q == HALF_LAST) begin
          st_d  = SQ_STOP_B;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      SQ_STOP_B: begin
        if (tmr_q == HALF_LAST) begin
          st_d  = SQ_IDLE;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      default: begin
        st_d  = SQ_IDLE;
        tmr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      tmr_q <= '0;
      pc_q  <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      pc_q  <= pc_d;
    end
  end

  assign scl_low = (st_q == SQ_LOW) || (st_q == SQ_STOP_A);
  assign sda_low = (st_q == SQ_STOP_A) || (st_q == SQ_STOP_B);
  assign busy    = (st_q != SQ_IDLE);

endmodule

// File: rtl/bus_unstick_ctrl.sv
module bus_unstick_ctrl #(
  parameter int N_CHAN      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 2_250_000,
  parameter int WAIT_CYC    = 2000,
  parameter int HALF_CYC    = 4545,
  parameter int MAX_PULSES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [N_CHAN-1:0] chan_en,
  input  logic              disc_strap,
  input  logic              clr_req,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              disconnect,
  output logic              fault
);

  // Reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  logic scl_s, sda_s, bus_idle;
  logic timeout_hit;
  logic seq_busy, seq_scl_low, seq_sda_low;
  logic fault_q, fault_d;
  logic disc_q, disc_d;
  logic clear_ok;
  logic flag_en;

  bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl_raw (scl_i),
    .sda_raw (sda_i),
    .scl_s   (scl_s),
    .sda_s   (sda_s)
  );

  assign bus_idle = scl_s && sda_s;

  stuck_window_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .mon_en      (|chan_en),
    .bus_idle    (bus_idle),
    .hold        (fault_q),
    .timeout_hit (timeout_hit)
  );

  recovery_sequencer #(
    .WAIT_CYC   (WAIT_CYC),
    .HALF_CYC   (HALF_CYC),
    .MAX_PULSES (MAX_PULSES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (timeout_hit && disc_strap),
    .bus_idle (bus_idle),
    .scl_low  (seq_scl_low),
    .sda_low  (seq_sda_low),
    .busy     (seq_busy)
  );

  assign clear_ok = fault_q && clr_req && bus_idle && !seq_busy;

  always_comb begin
    fault_d = fault_q;
    disc_d  = disc_q;
    if (timeout_hit) begin
      fault_d = 1'b1;
      disc_d  = disc_strap;
    end else if (clear_ok) begin
      fault_d = 1'b0;
      disc_d  = 1'b0;
    end
  end

  assign flag_en = timeout_hit || clear_ok;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fault_q <= 1'b0;
      disc_q  <= 1'b0;
    end else if (flag_en) begin
      fault_q <= fault_d;
      disc_q  <= disc_d;
    end
  end

  assign fault         = fault_q;
  assign disconnect    = disc_q;
  assign scl_drive_low = seq_scl_low;
  assign sda_drive_low = seq_sda_low;

endmodule

// File: rtl/bus_unstick_chk.sv
module bus_unstick_chk #(
  parameter int N_CHAN     = 2,
  parameter int MAX_PULSES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CHAN-1:0] chan_en,
  input logic              disc_strap,
  input logic              clr_req,
  input logic              scl_drive_low,
  input logic              sda_drive_low,
  input logic              disconnect,
  input logic              fault
);

  localparam int PW = $clog2(MAX_PULSES + 2);

  logic          scl_prev;
  logic [PW-1:0] burst_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev  <= 1'b0;
      burst_cnt <= '0;
    end else begin
      scl_prev <= scl_drive_low;
      if (!disconnect) begin
        burst_cnt <= '0;
      end else if (scl_drive_low && !scl_prev && !sda_drive_low) begin
        burst_cnt <= burst_cnt + PW'(1);
      end
    end
  end

  // R2
  fault_needs_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(|chan_en));

  // R3
  disc_needs_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disconnect) |-> disc_strap);

  // R9
  disc_within_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect |-> fault);

  // R9
  fault_clear_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> $past(clr_req));

  // R8
  drive_only_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disconnect |-> (!scl_drive_low && !sda_drive_low));

  // R5
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cnt <= PW'(MAX_PULSES));

  // R6
  stop_release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> !scl_drive_low);

endmodule

bind bus_unstick_ctrl bus_unstick_chk #(
  .N_CHAN     (N_CHAN),
  .MAX_PULSES (MAX_PULSES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .chan_en       (chan_en),
  .disc_strap    (disc_strap),
  .clr_req       (clr_req),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .disconnect    (disconnect),
  .fault         (fault)
);

// File: tb/tb_bus_unstick_ctrl.sv
module tb_bus_unstick_ctrl;

  localparam int NCH = 2;
  localparam int SS  = 2;
  localparam int TO  = 200;
  localparam int WC  = 20;
  localparam int HC  = 10;
  localparam int MP  = 16;

  logic           clk;
  logic           rst_n;
  logic           scl_i, sda_i;
  logic [NCH-1:0] chan_en;
  logic           disc_strap, clr_req;
  logic           scl_drive_low, sda_drive_low, disconnect, fault;

  // Simple wired-AND bus model: target may hold lines low
  logic hold_sda, hold_scl;
  assign scl_i = !scl_drive_low && !hold_scl;
  assign sda_i = !sda_drive_low && !hold_sda;

  bus_unstick_ctrl #(
    .N_CHAN(NCH), .SYNC_STAGES(SS), .TIMEOUT_CYC(TO),
    .WAIT_CYC(WC), .HALF_CYC(HC), .MAX_PULSES(MP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .chan_en(chan_en), .disc_strap(disc_strap), .clr_req(clr_req),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .disconnect(disconnect), .fault(fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Monitor of output activity
  logic mon_rst;
  int   cyc = 0;
  int   pulses, stops, fault_cyc, first_rise, low_run, last_low, bad_fault;
  logic p_scl, p_sda, p_fault;

  initial begin
    p_scl = 0; p_sda = 0; p_fault = 0;
    pulses = 0; stops = 0; fault_cyc = -1; first_rise = -1;
    low_run = 0; last_low = 0; bad_fault = 0;
  end

  always @(negedge clk) begin
    cyc++;
    if (mon_rst) begin
      pulses = 0; stops = 0; fault_cyc = -1; first_rise = -1;
      low_run = 0; last_low = 0; bad_fault = 0;
    end else begin
      if (fault && !p_fault) fault_cyc = cyc;
      if (scl_drive_low && !p_scl) begin
        if (!sda_drive_low) pulses++;
        if (first_rise < 0) first_rise = cyc;
      end
      if (scl_drive_low) low_run++;
      else if (p_scl) begin last_low = low_run; low_run = 0; end
      if (!sda_drive_low && p_sda && !scl_drive_low) stops++;
      if (sda_drive_low && !fault) bad_fault = 1;
    end
    p_scl = scl_drive_low; p_sda = sda_drive_low; p_fault = fault;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mon_clear();
    mon_rst = 1'b1;
    tick(1);
    mon_rst = 1'b0;
  endtask

  task automatic free_and_clear();
    hold_sda = 1'b0;
    hold_scl = 1'b0;
    tick(SS + 2);
    clr_req = 1'b1;
    tick(1);
    clr_req = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hold_sda = 0; hold_scl = 0; chan_en = '0;
    disc_strap = 0; clr_req = 0; mon_rst = 0;
    tick(4);
    chk("R10", "fault in reset", fault, 0);
    chk("R10", "disconnect in reset", disconnect, 0);
    rst_n = 1'b1;
    tick(4);
    chk("R10", "drives after reset", {30'd0, scl_drive_low, sda_drive_low}, 0);
    chk("R10", "fault after reset", fault, 0);
  endtask

  task automatic t_no_channel();
    chan_en = '0; disc_strap = 1'b1;
    mon_clear();
    hold_sda = 1'b1;
    tick(3 * TO);
    chk("R2", "fault with channels off", fault, 0);
    chk("R2", "pulses with channels off", pulses, 0);
    hold_sda = 1'b0;
    tick(SS + 2);
  endtask

  task automatic t_window();
    chan_en = 2'b10; disc_strap = 1'b0;
    mon_clear();
    hold_scl = 1'b1;
    tick(TO - 1);
    hold_scl = 1'b0;
    tick(1);
    hold_scl = 1'b1;
    tick(SS + TO - 1);
    chk("R1", "fault one cycle before window end", fault, 0);
    tick(1);
    chk("R1", "fault at window end", fault, 1);
    chk("R3", "no disconnect with strap low", disconnect, 0);
    free_and_clear();
    tick(1);
    chk("R9", "fault cleared on idle bus", fault, 0);
  endtask

  task automatic t_flag_only();
    chan_en = 2'b01; disc_strap = 1'b0;
    mon_clear();
    hold_sda = 1'b1;
    tick(SS + TO);
    chk("R3", "fault with strap low", fault, 1);
    tick(500);
    chk("R8", "no disconnect", disconnect, 0);
    chk("R8", "no scl pulses", pulses, 0);
    chk("R8", "no scl drive seen", first_rise, -1);
    clr_req = 1'b1;
    tick(1);
    clr_req = 1'b0;
    tick(1);
    chk("R9", "clear ignored while stuck", fault, 1);
    free_and_clear();
    tick(1);
    chk("R9", "cleared after release", fault, 0);
  endtask

  task automatic t_full_recovery();
    chan_en = 2'b11; disc_strap = 1'b1;
    mon_clear();
    hold_sda = 1'b1;
    tick(SS + TO);
    chk("R3", "fault with strap high", fault, 1);
    chk("R3", "disconnect with strap high", disconnect, 1);
    tick(WC + 2 * HC * MP + 2 * HC + 40);
    chk("R4", "wait before first pulse", first_rise - fault_cyc, WC);
    chk("R5", "pulse count when stuck", pulses, MP);
    chk("R5", "low phase length", last_low, HC);
    chk("R6", "stop count", stops, 1);
    chk("R9", "fault sticky after sequence", fault, 1);
    chk("R9", "disconnect held after sequence", disconnect, 1);
    free_and_clear();
    tick(1);
    chk("R9", "disconnect cleared", disconnect, 0);
  endtask

  task automatic t_release_at(input int n, input string req);
    int guard;
    chan_en = 2'b01; disc_strap = 1'b1;
    mon_clear();
    hold_sda = 1'b1;
    guard = 0;
    while (pulses < n && guard < 2000) begin
      tick(1);
      guard++;
    end
    hold_sda = 1'b0;
    clr_req  = 1'b1;
    tick(4 * HC + 20);
    clr_req = 1'b0;
    chk(req, "pulses after release", pulses, n);
    chk("R6", "one stop after release", stops, 1);
    chk("R9", "no flag drop while sequence drives", bad_fault, 0);
    chk("R9", "flag cleared once sequence idle", fault, 0);
    tick(5);
  endtask

  initial begin : main
    t_reset();
    t_no_channel();
    t_window();
    t_flag_only();
    t_full_recovery();
    t_release_at(3, "R7");
    t_release_at(MP, "R5");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule